// File: doc/BRIEF.md
# Dual-Strobe Presettable Up/Down Counter

This block is a small counter with two separate count strobes: a rising edge on the up strobe adds one, and a rising edge on the down strobe subtracts one. Each strobe counts only while the other one rests at its idle high level. A parameter sets the counting range. The binary range is 0 to 15 and the decimal range is 0 to 9, and both wrap at the ends. An active-low parallel load copies four load inputs into the count. An active-high clear forces the count to zero, and clear wins over load.

Both strobes come in asynchronously. Each one passes through a synchronizer into the system clock, and a rising edge is found by comparing the synchronized value with its value one cycle earlier. Clear and load act on the next system clock edge and do not wait for a strobe.

Two active-low cascade outputs drive the strobes of a following stage. Borrow goes low at the floor of the range while the down strobe is low. Carry goes low at the top of the range while the up strobe is low. Each of them therefore rises once per wrap.

Top module: `dual_strobe_counter`

## Requirements
- R1: While clear_i is high at a clock edge, count_o is 0 after that edge, whatever load_ni and the strobes are doing.
- R2: While clear_i is low and load_ni is low at a clock edge, count_o takes the value of load_val_i after that edge, and the strobes have no effect.
- R3: A rising edge on up_strobe_i while dn_strobe_i is high adds one to count_o. The new value appears at the third system clock edge after the input change.
- R4: A rising edge on dn_strobe_i while up_strobe_i is high subtracts one from count_o, with the same latency as R3.
- R5: A rising edge on either strobe while the other strobe is low leaves count_o unchanged.
- R6: If both strobes rise in the same synchronized cycle, count_o is unchanged.
- R7: With DECIMAL=0, an up count wraps from 15 to 0 and a down count wraps from 0 to 15.
- R8: With DECIMAL=1, an up count wraps from 9 to 0 and a down count wraps from 0 to 9.
- R9: With DECIMAL=1, a loaded value from 10 to 15 goes to 0 on the next up count and to 9 on the next down count.
- R10: carry_no is low exactly while count_o equals the maximum (9 or 15) and the synchronized up strobe is low. Otherwise it is high.
- R11: borrow_no is low exactly while count_o is 0 and the synchronized down strobe is low. Otherwise it is high.
- R12: A low rst_ni clears count_o to 0 asynchronously and sets both synchronized strobes to their idle high level.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous system reset, active low |
| clear_i | input | 1 | Master clear, active high, highest priority |
| load_ni | input | 1 | Parallel load enable, active low |
| load_val_i | input | WIDTH | Parallel load value |
| up_strobe_i | input | 1 | Count-up strobe, idle high, asynchronous |
| dn_strobe_i | input | 1 | Count-down strobe, idle high, asynchronous |
| count_o | output | WIDTH | Current count |
| carry_no | output | 1 | Cascade carry, active low |
| borrow_no | output | 1 | Cascade borrow, active low |

## Verification
The assertions assume that each strobe stays at one level for at least two system clocks, so that every edge crosses the synchronizer cleanly and cannot be missed. They also assume that clear_i, load_ni and load_val_i are synchronous to clk_i. The stimulus changes inputs only on falling clock edges. It holds every strobe level for five cycles, and it raises a strobe while the other one is low only on purpose, to exercise the gating and the simultaneous-edge case.

// File: rtl/dsc_pkg.sv
package dsc_pkg;
  typedef enum logic [2:0] {
    OP_HOLD,
    OP_INC,
    OP_DEC,
    OP_LOAD,
    OP_CLEAR
  } cnt_op_e;
endpackage

// File: rtl/strobe_sync.sv
module strobe_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic strobe_i,
  output logic level_o,
  output logic rise_o
);
  logic [STAGES-1:0] sync_q;
  logic              prev_q;

  genvar g;
  generate
    for (g = 0; g < STAGES; g++) begin : g_stage
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) sync_q[g] <= 1'b1;
        else if (g == 0) sync_q[g] <= strobe_i;
        else sync_q[g] <= sync_q[(g > 0) ? g-1 : 0];
      end
    end
  endgenerate

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) prev_q <= 1'b1;
    else         prev_q <= sync_q[STAGES-1];
  end

  assign level_o = sync_q[STAGES-1];
  assign rise_o  = sync_q[STAGES-1] & ~prev_q;
endmodule

// File: rtl/count_core.sv
module count_core
  import dsc_pkg::*;
#(
  parameter int              WIDTH   = 4,
  parameter logic [WIDTH-1:0] MAX_VAL = '1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  cnt_op_e          op_i,
  input  logic [WIDTH-1:0] load_val_i,
  output logic [WIDTH-1:0] count_o
);
  logic [WIDTH-1:0] count_q, count_d;

  always_comb begin
    count_d = count_q;
    unique case (op_i)
      OP_CLEAR: count_d = '0;
      OP_LOAD:  count_d = load_val_i;
      // out-of-range values fold to the ends of the range
      OP_INC:   count_d = (count_q >= MAX_VAL) ? '0 : count_q + 1'b1;
      OP_DEC:   count_d = (count_q == '0 || count_q > MAX_VAL) ? MAX_VAL : count_q - 1'b1;
      default:  count_d = count_q;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) count_q <= '0;
    else         count_q <= count_d;
  end

  assign count_o = count_q;
endmodule

// File: rtl/dual_strobe_counter.sv
module dual_strobe_counter
  import dsc_pkg::*;
#(
  parameter int WIDTH       = 4,
  parameter bit DECIMAL     = 1'b0,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clear_i,
  input  logic             load_ni,
  input  logic [WIDTH-1:0] load_val_i,
  input  logic             up_strobe_i,
  input  logic             dn_strobe_i,
  output logic [WIDTH-1:0] count_o,
  output logic             carry_no,
  output logic             borrow_no
);
  localparam logic [WIDTH-1:0] MAX_VAL = DECIMAL ? WIDTH'(9) : {WIDTH{1'b1}};

  logic    up_lvl, up_rise, dn_lvl, dn_rise;
  logic    inc_en, dec_en;
  cnt_op_e op;

  strobe_sync #(.STAGES(SYNC_STAGES)) u_up_sync (
    .clk_i(clk_i), .rst_ni(rst_ni), .strobe_i(up_strobe_i),
    .level_o(up_lvl), .rise_o(up_rise)
  );

  strobe_sync #(.STAGES(SYNC_STAGES)) u_dn_sync (
    .clk_i(clk_i), .rst_ni(rst_ni), .strobe_i(dn_strobe_i),
    .level_o(dn_lvl), .rise_o(dn_rise)
  );

  // each strobe is gated by the idle-high level of the other
  assign inc_en = up_rise & dn_lvl;
  assign dec_en = dn_rise & up_lvl;

  always_comb begin
    if (clear_i)               op = OP_CLEAR;
    else if (!load_ni)         op = OP_LOAD;
    else if (inc_en && !dec_en) op = OP_INC;
    else if (dec_en && !inc_en) op = OP_DEC;
    else                       op = OP_HOLD;
  end

  count_core #(.WIDTH(WIDTH), .MAX_VAL(MAX_VAL)) u_core (
    .clk_i(clk_i), .rst_ni(rst_ni), .op_i(op),
    .load_val_i(load_val_i), .count_o(count_o)
  );

  assign carry_no  = ~((count_o == MAX_VAL) & ~up_lvl);
  assign borrow_no = ~((count_o == '0) & ~dn_lvl);
endmodule

// File: rtl/dual_strobe_counter_chk.sv
module dual_strobe_counter_chk #(
  parameter int              WIDTH   = 4,
  parameter logic [WIDTH-1:0] MAX_VAL = '1
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             clear_i,
  input logic             load_ni,
  input logic [WIDTH-1:0] load_val_i,
  input logic [WIDTH-1:0] count_o,
  input logic             carry_no,
  input logic             borrow_no,
  input logic             up_lvl,
  input logic             up_rise,
  input logic             dn_lvl,
  input logic             dn_rise
);
  // R1
  clear_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clear_i |=> count_o == '0);

  // R2
  load_follow_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!clear_i && !load_ni) |=> count_o == $past(load_val_i));

  // R5
  idle_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!clear_i && load_ni && !up_rise && !dn_rise) |=> $stable(count_o));

  // R6
  both_rise_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!clear_i && load_ni && up_rise && dn_rise) |=> $stable(count_o));

  // R7 R8
  up_wrap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!clear_i && load_ni && up_rise && dn_lvl && !dn_rise && count_o == MAX_VAL) |=> count_o == '0);

  // R10
  carry_at_max_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !carry_no |-> (count_o == MAX_VAL && !up_lvl));

  // R11
  borrow_at_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !borrow_no |-> (count_o == '0 && !dn_lvl));
endmodule

bind dual_strobe_counter dual_strobe_counter_chk #(.WIDTH(WIDTH), .MAX_VAL(MAX_VAL)) chk_i (
  .clk_i(clk_i), .rst_ni(rst_ni), .clear_i(clear_i), .load_ni(load_ni),
  .load_val_i(load_val_i), .count_o(count_o), .carry_no(carry_no),
  .borrow_no(borrow_no), .up_lvl(up_lvl), .up_rise(up_rise),
  .dn_lvl(dn_lvl), .dn_rise(dn_rise)
);

// File: tb/dual_strobe_counter_tb_top.sv
module dual_strobe_counter_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int HOLD       = 5;

  // vector: op[13:12] (0 up, 1 down, 2 load), val[11:8], exp_bin[7:4], exp_dec[3:0]
  localparam logic [13:0] VEC [14] = '{
    {2'd0, 4'd0,  4'd1,  4'd1},
    {2'd1, 4'd0,  4'd0,  4'd0},
    {2'd1, 4'd0,  4'd15, 4'd9},
    {2'd0, 4'd0,  4'd0,  4'd0},
    {2'd2, 4'd9,  4'd9,  4'd9},
    {2'd0, 4'd0,  4'd10, 4'd0},
    {2'd2, 4'd12, 4'd12, 4'd12},
    {2'd0, 4'd0,  4'd13, 4'd0},
    {2'd2, 4'd12, 4'd12, 4'd12},
    {2'd1, 4'd0,  4'd11, 4'd9},
    {2'd2, 4'd15, 4'd15, 4'd15},
    {2'd0, 4'd0,  4'd0,  4'd0},
    {2'd2, 4'd0,  4'd0,  4'd0},
    {2'd1, 4'd0,  4'd15, 4'd9}
  };

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       clear = 1'b0;
  logic       load_n = 1'b1;
  logic [3:0] load_val = '0;
  logic       up = 1'b1;
  logic       dn = 1'b1;
  logic [3:0] cnt_b, cnt_d;
  logic       carry_b, carry_d, borrow_b, borrow_d;
  int         n_run = 0;
  int         n_fail = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  dual_strobe_counter #(.WIDTH(4), .DECIMAL(1'b0)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .clear_i(clear), .load_ni(load_n),
    .load_val_i(load_val), .up_strobe_i(up), .dn_strobe_i(dn),
    .count_o(cnt_b), .carry_no(carry_b), .borrow_no(borrow_b)
  );

  dual_strobe_counter #(.WIDTH(4), .DECIMAL(1'b1)) dut_dec_i (
    .clk_i(clk), .rst_ni(rst_n), .clear_i(clear), .load_ni(load_n),
    .load_val_i(load_val), .up_strobe_i(up), .dn_strobe_i(dn),
    .count_o(cnt_d), .carry_no(carry_d), .borrow_no(borrow_d)
  );

  task automatic chk(input string req, input int act, input int exp);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic wait_cyc(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic pulse_up();
    up = 1'b0; wait_cyc(HOLD); up = 1'b1; wait_cyc(HOLD);
  endtask

  task automatic pulse_dn();
    dn = 1'b0; wait_cyc(HOLD); dn = 1'b1; wait_cyc(HOLD);
  endtask

  task automatic do_load(input logic [3:0] v);
    load_val = v; load_n = 1'b0; wait_cyc(2); load_n = 1'b1; wait_cyc(2);
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    wait_cyc(3);
    // R12 reset state
    chk("R12 count bin", cnt_b, 0);
    chk("R12 count dec", cnt_d, 0);
    chk("R12 carry idle", carry_b, 1);
    chk("R12 borrow idle", borrow_b, 1);
    rst_n = 1'b1;
    wait_cyc(3);

    for (int i = 0; i < 14; i++) begin
      case (VEC[i][13:12])
        2'd0: pulse_up();
        2'd1: pulse_dn();
        default: do_load(VEC[i][11:8]);
      endcase
      chk($sformatf("R3/R4/R7 vec %0d bin", i), cnt_b, VEC[i][7:4]);
      chk($sformatf("R8/R9 vec %0d dec", i), cnt_d, VEC[i][3:0]);
    end

    // R3 latency: count unchanged after 2 edges, changed after 3
    do_load(4'd3);
    up = 1'b0; wait_cyc(HOLD);
    up = 1'b1; wait_cyc(2);
    chk("R3 before third edge", cnt_b, 3);
    wait_cyc(1);
    chk("R3 at third edge", cnt_b, 4);
    wait_cyc(HOLD);

    // R5 up edge while down low is ignored
    dn = 1'b0; wait_cyc(HOLD);
    up = 1'b0; wait_cyc(HOLD);
    up = 1'b1; wait_cyc(HOLD);
    chk("R5 gated up bin", cnt_b, 4);
    chk("R5 gated up dec", cnt_d, 4);
    dn = 1'b1; wait_cyc(HOLD);
    chk("R4 down after gating", cnt_b, 3);

    // R6 simultaneous rising edges
    up = 1'b0; dn = 1'b0; wait_cyc(HOLD);
    up = 1'b1; dn = 1'b1; wait_cyc(HOLD);
    chk("R6 both rise", cnt_b, 3);

    // R2 load overrides strobes
    load_val = 4'd6; load_n = 1'b0; wait_cyc(2);
    up = 1'b0; wait_cyc(HOLD); up = 1'b1; wait_cyc(HOLD);
    chk("R2 load held bin", cnt_b, 6);
    chk("R2 load held dec", cnt_d, 6);
    load_val = 4'd2; wait_cyc(2);
    chk("R2 load follows", cnt_b, 2);

    // R1 clear overrides load
    clear = 1'b1; wait_cyc(2);
    chk("R1 clear over load", cnt_b, 0);
    clear = 1'b0; load_n = 1'b1; wait_cyc(2);

    // R10 carry
    do_load(4'd9);
    up = 1'b0; wait_cyc(HOLD);
    chk("R10 carry dec at 9", carry_d, 0);
    chk("R10 carry bin at 9", carry_b, 1);
    up = 1'b1; wait_cyc(HOLD);
    chk("R10 carry released", carry_d, 1);
    do_load(4'd15);
    up = 1'b0; wait_cyc(HOLD);
    chk("R10 carry bin at 15", carry_b, 0);
    up = 1'b1; wait_cyc(HOLD);

    // R11 borrow
    do_load(4'd0);
    chk("R11 borrow idle high", borrow_b, 1);
    dn = 1'b0; wait_cyc(HOLD);
    chk("R11 borrow bin", borrow_b, 0);
    chk("R11 borrow dec", borrow_d, 0);
    dn = 1'b1; wait_cyc(HOLD);
    chk("R11 borrow released", borrow_b, 1);

    // R12 async reset mid-count
    do_load(4'd5);
    #(CLK_PERIOD/4) rst_n = 1'b0;
    #1 chk("R12 async clear", cnt_b, 0);
    wait_cyc(1); rst_n = 1'b1; wait_cyc(2);

    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule